// File: doc/BRIEF.md
# OTP Protection Register Controller

This block holds the one-time-programmable protection area of a parallel flash device and serves it over a simple command bus. There are nine 16-bit words at word offsets 0x80 to 0x88. Offset 0x80 is a lock word. Offsets 0x81 to 0x84 form a factory segment, loaded at reset from a parameter. Offsets 0x85 to 0x88 form a user segment, which starts out erased.

Programming takes two bus cycles. The first is a command cycle with opcode C0h. The second is a data cycle that carries the target offset and the word to program. A program can only clear bits, and each segment can be frozen for good through its bit in the lock word. A status byte reports three things: a ready flag that stays low for a fixed busy time, a program-error bit and a locked-segment error bit. The two error bits stay set until a clear-status command arrives. Any word offset can be read back.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset, status reads 80h. The lock word reads FFFEh, with bit 0 clear because the factory segment is locked. Factory word 0x81+i reads FACTORY_ID[16i+15:16i]. User words read FFFFh.
- R2: A command cycle with wdata[7:0]=C0h followed by a data cycle programs the word at offset `addr` (0x80–0x88) that is writable.
- R3: Programming only clears bits. The stored word becomes the old word AND wdata.
- R4: A program at an offset outside 0x80–0x88 sets status bit 4 only and changes no stored word.
- R5: A program into the factory segment (0x81–0x84) sets status bits 4 and 1 and changes nothing.
- R6: Programming FFFDh to 0x80 clears lock bit 1. After that, a program to 0x85–0x88 or to 0x80 sets status bits 4 and 1 and changes nothing.
- R7: Once lock bit 1 is clear, no command sequence or status clear makes it 1 again.
- R8: Status bit 7 (ready) goes low for exactly BUSY_CYCLES clocks after each data cycle. Command and data cycles that arrive while ready is low are ignored.
- R9: Error bits stay set through later operations until a command cycle with wdata[7:0]=50h clears both.
- R10: If a command cycle arrives in place of the expected data cycle, the sequence is aborted and nothing is written. A data cycle that has no C0h before it is ignored.
- R11: A read returns the stored word one clock after `rd_en`, with `rd_valid` high. Offsets outside 0x80–0x88 read FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command cycle strobe, opcode in wdata[7:0] |
| dat_we | input | 1 | Data cycle strobe, offset in addr, word in wdata |
| rd_en | input | 1 | Read request for offset addr |
| addr | input | 8 | Word offset |
| wdata | input | 16 | Opcode or program data |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | rd_data valid this cycle |
| status | output | 8 | bit7 ready, bit4 program error, bit1 lock error, others 0 |

## Verification
A wrong stored word or lock bit shows up at the first read of that offset, one clock after the request. A wrong lock decision shows up in the status byte as soon as the data cycle has completed. A wrong sequencer state, such as staying armed after an abort or decoding during busy, causes an unexpected write, and the read-back that follows exposes it. A busy counter that is off by one changes the count of ready-low clocks that the bench measures after each program.

// File: rtl/otp_prot_reg.sv
module otp_prot_reg #(
  parameter int          BUSY_CYCLES = 4,
  parameter logic [63:0] FACTORY_ID  = 64'h0123_4567_89AB_CDEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        dat_we,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic [7:0]  status
);
  localparam int         NWORDS = 9;
  localparam logic [7:0] BASE   = 8'h80;
  localparam int         CW     = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] OP_PROG = 8'hC0;
  localparam logic [7:0] OP_CLR  = 8'h50;

  logic [15:0]   words [NWORDS];
  logic          armed, pgm_err, lock_err;
  logic [CW-1:0] busy_cnt;

  wire       ready    = (busy_cnt == '0);
  wire       in_range = (addr >= BASE) && (addr < BASE + 8'(NWORDS));
  wire [3:0] idx      = 4'(addr - BASE);
  wire       seg_locked = (idx >= 4'd1 && idx <= 4'd4) ? ~words[0][0] : ~words[0][1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words[0] <= 16'hFFFE;
      for (int i = 1; i <= 4; i++) words[i] <= FACTORY_ID[16*(i-1) +: 16];
      for (int i = 5; i < NWORDS; i++) words[i] <= 16'hFFFF;
      armed    <= 1'b0;
      pgm_err  <= 1'b0;
      lock_err <= 1'b0;
      busy_cnt <= '0;
    end else if (!ready) begin
      busy_cnt <= busy_cnt - 1'b1;
    end else if (cmd_we) begin
      armed <= (wdata[7:0] == OP_PROG);
      if (wdata[7:0] == OP_CLR) begin
        pgm_err  <= 1'b0;
        lock_err <= 1'b0;
      end
    end else if (dat_we && armed) begin
      armed    <= 1'b0;
      busy_cnt <= CW'(BUSY_CYCLES);
      if (!in_range) begin
        pgm_err <= 1'b1;
      end else if (seg_locked) begin
        pgm_err  <= 1'b1;
        lock_err <= 1'b1;
      end else begin
        words[idx] <= words[idx] & wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 16'hFFFF;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= in_range ? words[idx] : 16'hFFFF;
    end
  end

  assign status = {ready, 2'b00, pgm_err, 2'b00, lock_err, 1'b0};
endmodule

// File: rtl/otp_prot_reg_chk.sv
module otp_prot_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic       dat_we,
  input logic [7:0] opcode,
  input logic       ready,
  input logic       pgm_err,
  input logic       lock_err,
  input logic       user_lock
);
  assert_busy_from_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(dat_we));
  assert_err_from_program_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_err) |-> $past(dat_we));
  assert_lock_err_with_pgm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> pgm_err);
  assert_clear_by_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_err) |-> $past(cmd_we && opcode == 8'h50));
  assert_lock_permanent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(user_lock) |-> !user_lock);
endmodule

bind otp_prot_reg otp_prot_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .dat_we(dat_we),
  .opcode(wdata[7:0]), .ready(status[7]), .pgm_err(status[4]),
  .lock_err(status[1]), .user_lock(words[0][1])
);

// File: tb/otp_prot_reg_tb.sv
`timescale 1ns/1ps
module otp_prot_reg_tb_top;
  localparam int          BUSY = 4;
  localparam logic [63:0] FID  = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst_n = 0, cmd_we = 0, dat_we = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [7:0]  status;
  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  otp_prot_reg #(.BUSY_CYCLES(BUSY), .FACTORY_ID(FID)) dut_i (
    .clk, .rst_n, .cmd_we, .dat_we, .rd_en, .addr, .wdata,
    .rd_data, .rd_valid, .status);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rd_valid) begin
    if (exp_q.size() == 0) check("R11 unexpected rd_valid", 16'h1, 16'h0);
    else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cmd(input logic [7:0] op);
    @(negedge clk); cmd_we = 1; wdata = {8'h00, op};
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic dat(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); dat_we = 1; addr = a; wdata = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!status[7]) begin n++; @(negedge clk); end
  endtask

  task automatic prog(input logic [7:0] a, input logic [15:0] d);
    int n;
    cmd(8'hC0); dat(a, d); wait_idle(n);
  endtask

  initial begin
    #(4ns * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", {8'h0, status}, 16'h0080);
    rd(8'h80, 16'hFFFE, "R1 lock word");
    for (int i = 0; i < 4; i++) rd(8'h81 + 8'(i), FID[16*i +: 16], "R1 factory word");
    rd(8'h85, 16'hFFFF, "R1 user word");
    rd(8'h7F, 16'hFFFF, "R11 below range");
    rd(8'h89, 16'hFFFF, "R11 above range");

    cmd(8'hC0); dat(8'h85, 16'h12F0); wait_idle(n);
    check("R8 busy length", 16'(n), 16'(BUSY));
    rd(8'h85, 16'h12F0, "R2 program user word");
    prog(8'h85, 16'hFF0F);
    rd(8'h85, 16'h1200, "R3 and-only program");
    prog(8'h88, 16'hA5A5);
    rd(8'h88, 16'hA5A5, "R2 last user word");
    check("R2 status ok", {8'h0, status}, 16'h0080);

    prog(8'h90, 16'h0000);
    check("R4 out of range status", {8'h0, status}, 16'h0090);
    rd(8'h88, 16'hA5A5, "R4 storage unchanged");
    prog(8'h87, 16'h0F0F);
    check("R9 error sticky", {8'h0, status}, 16'h0090);
    rd(8'h87, 16'h0F0F, "R9 program after error");
    cmd(8'h50);
    check("R9 clear status", {8'h0, status}, 16'h0080);

    prog(8'h82, 16'h0000);
    check("R5 factory locked status", {8'h0, status}, 16'h0092);
    rd(8'h82, FID[31:16], "R5 factory unchanged");
    cmd(8'h50);
    check("R9 clear both bits", {8'h0, status}, 16'h0080);

    cmd(8'hC0); cmd(8'hFF); dat(8'h86, 16'h0000);
    check("R10 abort no busy", {8'h0, status}, 16'h0080);
    rd(8'h86, 16'hFFFF, "R10 abort no write");
    dat(8'h86, 16'h0000);
    rd(8'h86, 16'hFFFF, "R10 data without command");

    cmd(8'hC0); dat(8'h86, 16'h00FF);
    cmd(8'hC0); dat(8'h87, 16'h0000);
    wait_idle(n);
    rd(8'h87, 16'h0F0F, "R8 writes during busy ignored");
    rd(8'h86, 16'h00FF, "R2 second user word");
    dat(8'h87, 16'h0000);
    rd(8'h87, 16'h0F0F, "R8 command during busy not armed");

    prog(8'h80, 16'hFFFD);
    check("R6 lock program status", {8'h0, status}, 16'h0080);
    rd(8'h80, 16'hFFFC, "R6 lock word");
    prog(8'h86, 16'h0000);
    check("R6 user locked status", {8'h0, status}, 16'h0092);
    rd(8'h86, 16'h00FF, "R6 user unchanged");
    cmd(8'h50);
    prog(8'h80, 16'hFFFF);
    check("R6 lock word locked status", {8'h0, status}, 16'h0092);
    cmd(8'h50);
    rd(8'h80, 16'hFFFC, "R7 lock irreversible");
    prog(8'h85, 16'h0000);
    rd(8'h85, 16'h1200, "R7 still locked after clear");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("R11 pending reads", 16'(exp_q.size()), 16'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule